// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Counter

This block is an up-counting timer whose behaviour is chosen by a 4-bit mode code. It can run freely through the whole count range. It can clear on a programmable compare value to produce a chosen period. It can also run as a single-slope PWM time base, with a fixed or programmable period. An external prescaler supplies a one-cycle advance pulse (`tick`), and the counter moves only on those cycles. The CPU can write the count, two compare registers (A and B) and a capture/period register at any time.

The block only emits one-cycle strobes. These mark where the count crosses a compare value, reaches its period end, or sits at zero, and when the overflow, compare-A and capture flags should be set. Interrupt flags, edge capture, the prescaler and pin drivers sit outside the block. In the PWM modes, compare writes are held in a shadow register until the end of the period, so a running waveform never sees a half-updated value. The capture/period register is never shadowed.

There is no data stream through this block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `mc_timer16`

## Requirements
- R1: Mode 0x0 counts up without clearing and wraps from 0xFFFF to 0x0000. `ovf_set` is high on the tick cycle where the count is 0xFFFF, which is the edge at which it becomes zero. Mode codes not listed in R2, R3, R5 or R6 behave like mode 0x0.
- R2: In mode 0x4 the period end is the active compare-A value. When the count equals it on a tick cycle, `top_hit` and `cmpa_set` are high and the count becomes zero at that edge.
- R3: In mode 0xC the period end is the capture register. On a tick cycle where the count equals it, `cap_set` and `top_hit` are high and the count clears.
- R4: In modes 0x4 and 0xC the period value is not shadowed. If it is written below the current count, no clear happens until the count passes 0xFFFF (with `ovf_set`) and wraps to zero.
- R5: Modes 0x5, 0x6 and 0x7 use fixed period ends 0x00FF, 0x01FF and 0x03FF. On the tick cycle at the period end, `top_hit` and `ovf_set` are high, and the count returns to zero on the next edge.
- R6: Mode 0xE takes the period end from the capture register and mode 0xF from compare A. At the period end, `ovf_set` is high in the same cycle as `cap_set` (for 0xE) or `cmpa_set` (for 0xF).
- R7: In modes 0x5, 0x6, 0x7, 0xE and 0xF, a compare-A or compare-B write goes to a shadow register. The active value loads from the shadow only on the period-end tick cycle.
- R8: In modes 0x0, 0x4 and 0xC, a compare write changes the active value at the next clock edge.
- R9: In modes 0x5, 0x6 and 0x7, the bits of written compare values above the fixed period width (8, 9 or 10 bits) are stored as zero.
- R10: The count changes only on tick cycles, except for a CPU count write. That write takes effect at the next edge whether or not `tick` is high, and it replaces the increment.
- R11: On the first tick cycle after a CPU count write, `match_a`, `match_b`, `top_hit`, `cmpa_set` and `cap_set` stay low.
- R12: `match_b` is high on a tick cycle where the count equals the active compare-B value. `bottom_hit` is high on a tick cycle where the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset (CPU reset) |
| tick | input | 1 | timer advance pulse from the prescaler |
| mode | input | 4 | mode code |
| cnt_we | input | 1 | CPU write strobe for the count |
| cnt_wdata | input | 16 | count write value |
| ocra_we | input | 1 | CPU write strobe for compare A |
| ocra_wdata | input | 16 | compare A write value |
| ocrb_we | input | 1 | CPU write strobe for compare B |
| ocrb_wdata | input | 16 | compare B write value |
| cap_we | input | 1 | CPU write strobe for capture/period register |
| cap_wdata | input | 16 | capture/period write value |
| count | output | 16 | current count |
| match_a | output | 1 | compare A match strobe |
| match_b | output | 1 | compare B match strobe |
| top_hit | output | 1 | period-end strobe |
| bottom_hit | output | 1 | count-at-zero strobe |
| ovf_set | output | 1 | overflow flag set strobe |
| cmpa_set | output | 1 | compare A flag set strobe |
| cap_set | output | 1 | capture flag set strobe |

## Verification
The bench builds the block at its default width of 16 bits, so the 0xFFFF wrap and the three fixed PWM periods are tested at their real values. Rather than counting through 65536 ticks, it writes the count to a few steps before 0xFFFF, 0x00FF, 0x01FF or 0x03FF. This reaches the wrap, the late-low-period case and each fixed period end in a handful of cycles. Programmed periods are kept small (3 to 8), so the shadow-register hand-over at the period end can be followed over two consecutive periods.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    TOP_MAX   = 2'd0,
    TOP_FIXED = 2'd1,
    TOP_CAP   = 2'd2,
    TOP_CMPA  = 2'd3
  } top_src_e;

  typedef struct packed {
    logic     pwm;        // shadowed compares, overflow at period end
    logic     clr_at_top; // count clears at period end
    top_src_e src;
    logic [1:0] fix_sel;  // 0: 8 bit, 1: 9 bit, 2: 10 bit
  } mode_cfg_t;

  localparam int FIX_BASE_W = 8;
  localparam int FIX_NUM    = 3;
endpackage

// File: rtl/tmr16_mode_dec.sv
module tmr16_mode_dec
  import tmr16_pkg::*;
(
  input  logic [3:0] mode,
  output mode_cfg_t  cfg
);
  always_comb begin
    cfg = '{pwm: 1'b0, clr_at_top: 1'b0, src: TOP_MAX, fix_sel: 2'd0};
    case (mode)
      4'h4: begin cfg.clr_at_top = 1'b1; cfg.src = TOP_CMPA; end
      4'hC: begin cfg.clr_at_top = 1'b1; cfg.src = TOP_CAP;  end
      4'h5, 4'h6, 4'h7: begin
        cfg.pwm = 1'b1; cfg.clr_at_top = 1'b1; cfg.src = TOP_FIXED;
        cfg.fix_sel = mode[1:0] - 2'd1;
      end
      4'hE: begin cfg.pwm = 1'b1; cfg.clr_at_top = 1'b1; cfg.src = TOP_CAP;  end
      4'hF: begin cfg.pwm = 1'b1; cfg.clr_at_top = 1'b1; cfg.src = TOP_CMPA; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr16_top_sel.sv
module tmr16_top_sel
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  mode_cfg_t      cfg,
  input  logic [W-1:0]   cap,
  input  logic [W-1:0]   cmpa_act,
  output logic [W-1:0]   top,
  output logic [W-1:0]   wmask
);
  logic [W-1:0] fix_top [FIX_NUM];

  for (genvar g = 0; g < FIX_NUM; g++) begin : g_fix
    localparam int FW = FIX_BASE_W + g;
    assign fix_top[g] = W'((64'd1 << FW) - 64'd1);
  end

  logic [W-1:0] sel_fix;
  always_comb begin
    sel_fix = fix_top[0];
    if (cfg.fix_sel == 2'd1) sel_fix = fix_top[1];
    if (cfg.fix_sel == 2'd2) sel_fix = fix_top[2];
  end

  always_comb begin
    case (cfg.src)
      TOP_FIXED: top = sel_fix;
      TOP_CAP:   top = cap;
      TOP_CMPA:  top = cmpa_act;
      default:   top = '1;
    endcase
    wmask = (cfg.src == TOP_FIXED) ? sel_fix : '1;
  end
endmodule

// File: rtl/tmr16_cmp_reg.sv
module tmr16_cmp_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] wmask,
  input  logic         shadowed,
  input  logic         load,
  output logic [W-1:0] act
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act      <= '0;
    end else begin
      if (we) shadow_q <= wdata & wmask;
      if (shadowed) begin
        if (load) act <= shadow_q;
      end else if (we) begin
        act <= wdata & wmask;
      end
    end
  end

  // R7: a shadowed active value moves only at the period end
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shadowed && !load) |=> $stable(act));

  // R9: stored bits above the period width are zero
  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((shadow_q & ~$past(wmask)) == '0));
endmodule

// File: rtl/tmr16_cnt_core.sv
module tmr16_cnt_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic [W-1:0] top,
  input  logic         clr_at_top,
  input  logic         pwm,
  input  logic [W-1:0] cmpa,
  input  logic [W-1:0] cmpb,
  output logic [W-1:0] cnt,
  output logic         m_a,
  output logic         m_b,
  output logic         top_hit,
  output logic         bottom_hit,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = '1;

  logic quiet_q; // blocks matches on the tick after a count write
  logic live;

  assign live       = tick && !quiet_q;
  assign top_hit    = live && (cnt == top);
  assign m_a        = live && (cnt == cmpa);
  assign m_b        = live && (cnt == cmpb);
  assign bottom_hit = tick && (cnt == '0);
  assign ovf        = pwm ? top_hit : (tick && (cnt == MAXV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      quiet_q <= 1'b0;
    end else begin
      if (cnt_we)      quiet_q <= 1'b1;
      else if (tick)   quiet_q <= 1'b0;

      if (cnt_we)                        cnt <= cnt_wdata;
      else if (tick && clr_at_top && top_hit) cnt <= '0;
      else if (tick)                     cnt <= cnt + W'(1);
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt));
  assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt == $past(cnt_wdata)));
  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !(m_a || m_b || top_hit));
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt == MAXV) |=> (cnt == '0));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (top_hit && clr_at_top && !cnt_we) |=> (cnt == '0));
endmodule

// File: rtl/mc_timer16.sv
module mc_timer16
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [3:0]       mode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ocra_we,
  input  logic [CNT_W-1:0] ocra_wdata,
  input  logic             ocrb_we,
  input  logic [CNT_W-1:0] ocrb_wdata,
  input  logic             cap_we,
  input  logic [CNT_W-1:0] cap_wdata,
  output logic [CNT_W-1:0] count,
  output logic             match_a,
  output logic             match_b,
  output logic             top_hit,
  output logic             bottom_hit,
  output logic             ovf_set,
  output logic             cmpa_set,
  output logic             cap_set
);
  localparam int NCMP = 2;

  mode_cfg_t        cfg;
  logic [CNT_W-1:0] cap_q, top, wmask;
  logic [CNT_W-1:0] cmp_act [NCMP];
  logic             cmp_we  [NCMP];
  logic [CNT_W-1:0] cmp_wd  [NCMP];
  logic             load;

  assign cmp_we[0] = ocra_we;
  assign cmp_wd[0] = ocra_wdata;
  assign cmp_we[1] = ocrb_we;
  assign cmp_wd[1] = ocrb_wdata;

  tmr16_mode_dec u_dec (.mode(mode), .cfg(cfg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_we) cap_q <= cap_wdata;
  end

  tmr16_top_sel #(.W(CNT_W)) u_top (
    .cfg(cfg), .cap(cap_q), .cmpa_act(cmp_act[0]), .top(top), .wmask(wmask)
  );

  assign load = cfg.pwm && top_hit;

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    tmr16_cmp_reg #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .we(cmp_we[c]), .wdata(cmp_wd[c]),
      .wmask(wmask), .shadowed(cfg.pwm), .load(load), .act(cmp_act[c])
    );
  end

  tmr16_cnt_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .top(top), .clr_at_top(cfg.clr_at_top),
    .pwm(cfg.pwm), .cmpa(cmp_act[0]), .cmpb(cmp_act[1]), .cnt(count),
    .m_a(match_a), .m_b(match_b), .top_hit(top_hit),
    .bottom_hit(bottom_hit), .ovf(ovf_set)
  );

  assign cmpa_set = match_a;
  assign cap_set  = top_hit && (cfg.src == TOP_CAP);

  // R6: with compare A as period, overflow comes with the compare A flag
  assert_pwm_a_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && cfg.pwm && cfg.src == TOP_CMPA) |-> cmpa_set);
  // R6: with capture as period, overflow comes with the capture flag
  assert_pwm_cap_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && cfg.pwm && cfg.src == TOP_CAP) |-> cap_set);
endmodule

// File: tb/mc_timer16_tb.sv
module mc_timer16_tb;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [3:0]  mode = 4'h0;
  logic        cnt_we = 0, ocra_we = 0, ocrb_we = 0, cap_we = 0;
  logic [15:0] cnt_wdata = 0, ocra_wdata = 0, ocrb_wdata = 0, cap_wdata = 0;
  logic [15:0] count;
  logic match_a, match_b, top_hit, bottom_hit, ovf_set, cmpa_set, cap_set;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mc_timer16 u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic wr_cnt(input logic [15:0] v);
    tick = 0; cnt_we = 1; cnt_wdata = v; step(); cnt_we = 0;
  endtask
  task automatic wr_a(input logic [15:0] v);
    tick = 0; ocra_we = 1; ocra_wdata = v; step(); ocra_we = 0;
  endtask
  task automatic wr_b(input logic [15:0] v);
    tick = 0; ocrb_we = 1; ocrb_wdata = v; step(); ocrb_we = 0;
  endtask
  task automatic wr_cap(input logic [15:0] v);
    tick = 0; cap_we = 1; cap_wdata = v; step(); cap_we = 0;
  endtask
  task automatic set_mode(input logic [3:0] m);
    tick = 0; mode = m; step();
  endtask

  task automatic t_reset();
    chk("reset count", count, 0);
    chk("reset strobes", {match_a, match_b, top_hit, ovf_set, cmpa_set, cap_set}, 0);
  endtask

  task automatic t_normal(input logic [3:0] m);
    set_mode(m); wr_cnt(16'hFFFE); tick = 1; #0;
    chk("R1 ovf before max", ovf_set, 0);
    step(); chk("R1 at max", count, 16'hFFFF);
    chk("R1 ovf at max", ovf_set, 1);
    step(); chk("R1 wrapped", count, 0);
    chk("R12 bottom", bottom_hit, 1);
    tick = 0;
  endtask

  task automatic t_ctc_a();
    set_mode(4'h4); wr_a(16'd5); wr_cnt(0); tick = 1;
    for (int i = 0; i < 7; i++) begin
      chk("R2 ctc count", count, i % 6);
      chk("R2 cmpa flag", cmpa_set, (i == 5));
      chk("R2 top strobe", top_hit, (i == 5));
      step();
    end
    wr_a(16'd3); tick = 1;
    step(); step();
    chk("R8 direct count", count, 3);
    chk("R8 direct match", cmpa_set, 1);
    step(); chk("R8 clear at new top", count, 0);
    tick = 0;
  endtask

  task automatic t_ctc_cap();
    set_mode(4'hC); wr_cap(16'd3); wr_cnt(0); tick = 1;
    for (int i = 0; i < 5; i++) begin
      chk("R3 count", count, i % 4);
      chk("R3 cap flag", cap_set, (i == 3));
      step();
    end
    tick = 0;
  endtask

  task automatic t_ctc_late();
    set_mode(4'h4); wr_a(16'd5); wr_cnt(16'hFFF0); tick = 1;
    for (int i = 0; i < 16; i++) begin
      chk("R4 no top before wrap", top_hit, 0);
      chk("R4 ovf at max", ovf_set, (i == 15));
      step();
    end
    chk("R4 wrapped", count, 0);
    repeat (5) step();
    chk("R4 match after wrap", cmpa_set, 1);
    step(); chk("R4 cleared", count, 0);
    tick = 0;
  endtask

  task automatic t_fixed(input logic [3:0] m, input logic [15:0] topv);
    set_mode(m); wr_cnt(topv - 16'd1); tick = 1;
    step(); chk("R5 at fixed top", count, topv);
    chk("R5 top/ovf", {top_hit, ovf_set}, 2'b11);
    step(); chk("R5 cleared", count, 0);
    tick = 0;
  endtask

  task automatic t_mask();
    set_mode(4'h5); wr_b(16'h1234); wr_cnt(16'h00FE); tick = 1;
    step(); step(); // load at 0xFF
    wr_cnt(16'h0032); tick = 1;
    step(); step();
    chk("R9 masked count", count, 16'h34);
    chk("R9 masked match", match_b, 1);
    tick = 0;
  endtask

  task automatic t_shadow();
    set_mode(4'h4); wr_a(16'd8);
    set_mode(4'hF); wr_b(16'd3); wr_a(16'd4); wr_cnt(0); tick = 1;
    for (int i = 0; i < 9; i++) begin
      if (i == 3) chk("R7 old B active", match_b, 0);
      if (i == 4) chk("R7 old A active", cmpa_set, 0);
      step();
      if (i == 7) chk("R6 flags at top F", {top_hit, ovf_set, cmpa_set}, 3'b111);
    end
    chk("R7 period1 wrap", count, 0);
    chk("R12 bottom strobe", bottom_hit, 1);
    step(); step(); step();
    chk("R12 new B match", match_b, 1);
    step();
    chk("R7 new top", {top_hit, ovf_set, cmpa_set}, 3'b111);
    step(); chk("R7 short period wrap", count, 0);
    tick = 0;
  endtask

  task automatic t_pwm_cap();
    set_mode(4'hE); wr_cap(16'd4); wr_cnt(0); tick = 1;
    repeat (4) step();
    chk("R6 cap/ovf at top", {cap_set, ovf_set}, 2'b11);
    step(); chk("R6 cleared", count, 0);
    tick = 0;
  endtask

  task automatic t_tick();
    set_mode(4'h0); wr_cnt(16'h0100);
    step(); step();
    chk("R10 hold without tick", count, 16'h0100);
    tick = 1; cnt_we = 1; cnt_wdata = 16'h0020;
    step(); cnt_we = 0; tick = 0;
    chk("R10 write beats increment", count, 16'h0020);
  endtask

  task automatic t_quiet();
    set_mode(4'h4); wr_a(16'd5); wr_cnt(16'd5); tick = 1; #0;
    chk("R11 suppressed match", {match_a, top_hit, cmpa_set}, 0);
    step(); chk("R11 no clear", count, 6);
    wr_cnt(16'd4); tick = 1;
    step();
    chk("R11 match resumes", match_a, 1);
    set_mode(4'h0); wr_b(16'd7); wr_cnt(16'd6); tick = 1;
    step(); chk("R12 match_b", match_b, 1);
    tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    t_reset();
    t_normal(4'h0);
    t_normal(4'h1);
    t_ctc_a();
    t_ctc_cap();
    t_ctc_late();
    t_fixed(4'h5, 16'h00FF);
    t_fixed(4'h6, 16'h01FF);
    t_fixed(4'h7, 16'h03FF);
    t_mask();
    t_shadow();
    t_pwm_cap();
    t_tick();
    t_quiet();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule